// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which interrupt a 16550-style serial port reports and whether its interrupt line is raised. It takes the receive-side status (error flags, data-ready, receive FIFO fill level against a trigger level, a character-timeout flag), the modem-line change flags and the FIFO mode. From these it forms the interrupt identification byte that software reads. It also keeps the interrupt-enable register and the one piece of interrupt state that cannot be recomputed from status alone: the "transmit holding register empty" pending flag.

That flag is set and cleared by register traffic: a write of the transmit holding register, a transmit FIFO reset, a write to the enable register and a read of the identification byte. The surrounding register file decodes addresses and hands these to the block as one-cycle strobes. The identification byte is combinational from the held state and the current status. The interrupt line is a register computed from the state as it will be after the current edge, so that it follows any status change or strobe by exactly one clock.

Top module: `uart_irq_id`

## Requirements
- R1: After reset, `ierOut` reads 0x00, `iirOut` reads 0x01 and `irqOut` is low.
- R2: Enable bits are bit 0 receive data (also gates timeout), bit 1 transmit empty, bit 2 line status, bit 3 modem status. When several sources are enabled and active, the one reported is chosen in this order, first wins: line status, character timeout, received data, transmit empty, modem status.
- R3: `iirOut[3:0]` is 0x1 with nothing pending, 0x6 for line status, 0xC for character timeout, 0x4 for received data, 0x2 for transmit empty and 0x0 for modem status.
- R4: `iirOut[7:6]` is 2'b11 while `fifoEn` is high and 2'b00 otherwise; `iirOut[5:4]` is always zero.
- R5: The character timeout is reported only when enable bit 0 is set; no other enable bit unmasks it.
- R6: With `fifoEn` high, received data is reported only when `dataReady` is high and `rxCount >= rxTrigLevel`; with `fifoEn` low, `dataReady` alone suffices.
- R7: An `iirRdEn` strobe in a cycle where `iirOut[3:0]` is 0x2 clears the transmit-empty pending flag; the same strobe while another source is shown leaves it set.
- R8: An `ierWrEn` strobe that changes enable bit 1 sets the pending flag if the new bit is 1 and `thrEmpty` is high, and clears it otherwise; a write that keeps bit 1 unchanged leaves the flag alone.
- R9: `thrWrEn` clears the pending flag and `txFifoRst` sets it; when several of these strobes coincide, `txFifoRst` wins, then `thrWrEn`, then the enable write, then the identification read.
- R10: `ierOut[3:0]` holds the last value written through `ierWrData`; `ierOut[7:4]` is always zero.
- R11: `irqOut` is high exactly when the identification would not be 0x1, and it reflects a status change or strobe at the first rising edge after it.
- R12: Any one of the four `lineErr` bits raises the line status source; any one of the four `modemDelta` bits raises the modem source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ierWrEn | input | 1 | Enable register write strobe |
| ierWrData | input | 4 | Enable register write value |
| iirRdEn | input | 1 | Identification byte read strobe |
| thrWrEn | input | 1 | Transmit holding register write strobe |
| txFifoRst | input | 1 | Transmit FIFO reset strobe |
| thrEmpty | input | 1 | Transmit holding register is empty |
| lineErr | input | 4 | Overrun, parity, framing, break flags |
| dataReady | input | 1 | Receive data available |
| rxCount | input | CNT_W | Receive FIFO fill level |
| rxTrigLevel | input | CNT_W | Receive FIFO trigger level |
| fifoEn | input | 1 | FIFO mode active |
| timeoutPend | input | 1 | Character timeout pending |
| modemDelta | input | 4 | Modem line change flags |
| ierOut | output | 8 | Enable register readback |
| iirOut | output | 8 | Interrupt identification byte |
| irqOut | output | 1 | Interrupt request |

## Verification
The read of the identification byte and a transmit FIFO reset can land in the same cycle while the byte shows transmit-empty: the read would clear the pending flag while the reset sets it. The bench drives both strobes in one cycle with the flag already set and judges by the byte and the interrupt line afterwards, which must still show 0x2 and stay high. A line-error source hiding the transmit-empty source during a read is also provoked, and the flag must reappear once the error is removed.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam logic [3:0] ID_NONE  = 4'h1;
  localparam logic [3:0] ID_LINE  = 4'h6;
  localparam logic [3:0] ID_TMO   = 4'hC;
  localparam logic [3:0] ID_RXD   = 4'h4;
  localparam logic [3:0] ID_THRE  = 4'h2;
  localparam logic [3:0] ID_MODEM = 4'h0;

  // enable bit positions
  localparam int EN_RXD   = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  typedef struct packed {
    logic ierLoad;
    logic threSet;
    logic threClr;
  } irqCmd_t;

  typedef struct packed {
    logic [3:0] lineErr;
    logic       dataReady;
    logic       rxAtTrig;
    logic       timeoutPend;
    logic [3:0] modemDelta;
  } irqSrc_t;

  function automatic logic [3:0] pickId(input logic [3:0] ier,
                                        input logic thre,
                                        input irqSrc_t s);
    logic [3:0] id;
    id = ID_NONE;
    if (ier[EN_LINE] && (|s.lineErr))                      id = ID_LINE;
    else if (ier[EN_RXD] && s.timeoutPend)                 id = ID_TMO;
    else if (ier[EN_RXD] && s.dataReady && s.rxAtTrig)     id = ID_RXD;
    else if (ier[EN_THRE] && thre)                         id = ID_THRE;
    else if (ier[EN_MODEM] && (|s.modemDelta))             id = ID_MODEM;
    return id;
  endfunction

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic       ierWrEn,
  input  logic       ierNewThre,
  input  logic       ierCurThre,
  input  logic       thrEmpty,
  input  logic       thrWrEn,
  input  logic       txFifoRst,
  input  logic       iirRdEn,
  input  logic [3:0] curId,
  output irqCmd_t    cmd
);

  logic threEnFlip;
  assign threEnFlip = ierWrEn && (ierNewThre != ierCurThre);

  // strobe priority: fifo reset, holding write, enable write, id read
  always_comb begin
    cmd         = '0;
    cmd.ierLoad = ierWrEn;
    if (txFifoRst) begin
      cmd.threSet = 1'b1;
    end else if (thrWrEn) begin
      cmd.threClr = 1'b1;
    end else if (threEnFlip) begin
      if (ierNewThre && thrEmpty) cmd.threSet = 1'b1;
      else                        cmd.threClr = 1'b1;
    end else if (iirRdEn && (curId == ID_THRE)) begin
      cmd.threClr = 1'b1;
    end
  end

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  irqCmd_t          cmd,
  input  logic [3:0]       ierWrData,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigLevel,
  input  logic             fifoEn,
  input  logic             timeoutPend,
  input  logic [3:0]       modemDelta,
  output logic [3:0]       ierQ,
  output logic [3:0]       curId,
  output logic [7:0]       iirOut,
  output logic             irqOut
);

  logic       threQ;
  logic       threNext;
  logic [3:0] ierNext;
  logic [3:0] nextId;
  irqSrc_t    src;

  assign src.lineErr     = lineErr;
  assign src.dataReady   = dataReady;
  assign src.rxAtTrig    = !fifoEn || (rxCount >= rxTrigLevel);
  assign src.timeoutPend = timeoutPend;
  assign src.modemDelta  = modemDelta;

  assign ierNext  = cmd.ierLoad ? ierWrData : ierQ;
  assign threNext = cmd.threSet ? 1'b1 : (cmd.threClr ? 1'b0 : threQ);

  assign curId  = pickId(ierQ, threQ, src);
  assign nextId = pickId(ierNext, threNext, src);
  assign iirOut = {fifoEn, fifoEn, 2'b00, curId};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ierQ   <= '0;
      threQ  <= 1'b0;
      irqOut <= 1'b0;
    end else begin
      ierQ   <= ierNext;
      threQ  <= threNext;
      irqOut <= (nextId != ID_NONE);
    end
  end

  // R9: a fifo reset while the enable is held leaves the source pending
  a_r9_reset_pends: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.threSet && !cmd.ierLoad && ierQ[EN_THRE]) |=> (irqOut && threQ));

  // R12: modem source is only shown with its enable and a delta flag
  a_r12_modem_src: assert property (@(posedge clk) disable iff (!rstN)
    (curId == ID_MODEM) |-> (ierQ[EN_MODEM] && (|modemDelta)));

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ierWrEn,
  input  logic [3:0]       ierWrData,
  input  logic             iirRdEn,
  input  logic             thrWrEn,
  input  logic             txFifoRst,
  input  logic             thrEmpty,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigLevel,
  input  logic             fifoEn,
  input  logic             timeoutPend,
  input  logic [3:0]       modemDelta,
  output logic [7:0]       ierOut,
  output logic [7:0]       iirOut,
  output logic             irqOut
);

  irqCmd_t    cmd;
  logic [3:0] ierQ;
  logic [3:0] curId;

  uart_irq_ctrl u_ctrl (
    .ierWrEn    (ierWrEn),
    .ierNewThre (ierWrData[EN_THRE]),
    .ierCurThre (ierQ[EN_THRE]),
    .thrEmpty   (thrEmpty),
    .thrWrEn    (thrWrEn),
    .txFifoRst  (txFifoRst),
    .iirRdEn    (iirRdEn),
    .curId      (curId),
    .cmd        (cmd)
  );

  uart_irq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .ierWrData   (ierWrData),
    .lineErr     (lineErr),
    .dataReady   (dataReady),
    .rxCount     (rxCount),
    .rxTrigLevel (rxTrigLevel),
    .fifoEn      (fifoEn),
    .timeoutPend (timeoutPend),
    .modemDelta  (modemDelta),
    .ierQ        (ierQ),
    .curId       (curId),
    .iirOut      (iirOut),
    .irqOut      (irqOut)
  );

  assign ierOut = {4'h0, ierQ};

  logic anyStrobe;
  assign anyStrobe = ierWrEn || iirRdEn || thrWrEn || txFifoRst;

  // R7: a read that sees the transmit-empty id removes it
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (iirRdEn && (iirOut[3:0] == ID_THRE) && !txFifoRst && !ierWrEn)
      |=> (iirOut[3:0] != ID_THRE));

  // R11: with quiet strobes and steady status the line matches the id
  a_r11_irq_tracks: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!anyStrobe) && $stable(lineErr) && $stable(dataReady) &&
     $stable(rxCount) && $stable(rxTrigLevel) && $stable(fifoEn) &&
     $stable(timeoutPend) && $stable(modemDelta))
      |-> (irqOut == !iirOut[0]));

  // R2: an enabled line error always takes precedence
  a_r2_line_first: assert property (@(posedge clk) disable iff (!rstN)
    (ierOut[EN_LINE] && (|lineErr)) |-> (iirOut[3:0] == ID_LINE));

  // R10: upper enable bits never read back as set
  a_r10_ier_upper: assert property (@(posedge clk) disable iff (!rstN)
    ierOut[7:4] == 4'h0);

endmodule

// File: tb/uart_irq_id_tb.sv
module uart_irq_id_tb_top;

  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             ierWrEn = 1'b0;
  logic [3:0]       ierWrData = '0;
  logic             iirRdEn = 1'b0;
  logic             thrWrEn = 1'b0;
  logic             txFifoRst = 1'b0;
  logic             thrEmpty = 1'b0;
  logic [3:0]       lineErr = '0;
  logic             dataReady = 1'b0;
  logic [CNT_W-1:0] rxCount = '0;
  logic [CNT_W-1:0] rxTrigLevel = '0;
  logic             fifoEn = 1'b0;
  logic             timeoutPend = 1'b0;
  logic [3:0]       modemDelta = '0;
  logic [7:0]       ierOut;
  logic [7:0]       iirOut;
  logic             irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_irq_id #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .ierWrEn(ierWrEn), .ierWrData(ierWrData),
    .iirRdEn(iirRdEn), .thrWrEn(thrWrEn), .txFifoRst(txFifoRst),
    .thrEmpty(thrEmpty), .lineErr(lineErr), .dataReady(dataReady),
    .rxCount(rxCount), .rxTrigLevel(rxTrigLevel), .fifoEn(fifoEn),
    .timeoutPend(timeoutPend), .modemDelta(modemDelta),
    .ierOut(ierOut), .iirOut(iirOut), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [3:0] ier;
    logic [3:0] err;
    logic       dr;
    logic [4:0] cnt;
    logic [4:0] trig;
    logic       fen;
    logic       tmo;
    logic [3:0] dlt;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{4'hF, 4'h0, 1'b0, 5'd0, 5'd1, 1'b0, 1'b0, 4'h0, 8'h01},  // R3 none
    '{4'hF, 4'h1, 1'b1, 5'd0, 5'd1, 1'b0, 1'b1, 4'h1, 8'h06},  // R2 line first
    '{4'hF, 4'h0, 1'b1, 5'd0, 5'd1, 1'b0, 1'b1, 4'h1, 8'h0C},  // R2 timeout next
    '{4'hF, 4'h0, 1'b1, 5'd0, 5'd1, 1'b0, 1'b0, 4'h1, 8'h04},  // R6 no fifo
    '{4'hF, 4'h0, 1'b0, 5'd0, 5'd1, 1'b0, 1'b0, 4'h1, 8'h00},  // R3 modem
    '{4'hB, 4'h8, 1'b1, 5'd0, 5'd1, 1'b0, 1'b1, 4'h0, 8'h0C},  // R12 masked break
    '{4'hE, 4'h0, 1'b1, 5'd0, 5'd1, 1'b0, 1'b1, 4'h1, 8'h00},  // R5 gated
    '{4'hF, 4'h0, 1'b1, 5'd3, 5'd4, 1'b1, 1'b0, 4'h0, 8'hC1},  // R6 below trig
    '{4'hF, 4'h0, 1'b1, 5'd4, 5'd4, 1'b1, 1'b0, 4'h0, 8'hC4},  // R6 at trig
    '{4'hF, 4'h0, 1'b0, 5'd8, 5'd4, 1'b1, 1'b0, 4'h0, 8'hC1},  // R6 no data
    '{4'h7, 4'h0, 1'b0, 5'd0, 5'd1, 1'b0, 1'b0, 4'hF, 8'h01},  // R12 modem off
    '{4'h4, 4'h4, 1'b0, 5'd0, 5'd1, 1'b0, 1'b0, 4'h0, 8'h06},  // R12 framing
    '{4'h4, 4'h2, 1'b0, 5'd0, 5'd1, 1'b1, 1'b0, 4'h0, 8'hC6}   // R4 parity fifo
  };

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic checkIrq(input string tag, input logic exp);
    checks++;
    if (irqOut !== exp) begin
      fails++;
      $display("FAIL %s irq got=%0b exp=%0b", tag, irqOut, exp);
    end
  endtask

  task automatic pulse(input logic wr, input logic [3:0] d, input logic rd,
                       input logic tw, input logic fr);
    @(negedge clk);
    ierWrEn = wr; ierWrData = d; iirRdEn = rd; thrWrEn = tw; txFifoRst = fr;
    @(negedge clk);
    ierWrEn = 1'b0; iirRdEn = 1'b0; thrWrEn = 1'b0; txFifoRst = 1'b0;
  endtask

  task automatic clearSrc();
    lineErr = '0; dataReady = 1'b0; rxCount = '0; rxTrigLevel = 5'd1;
    fifoEn = 1'b0; timeoutPend = 1'b0; modemDelta = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check8("R1 ier", ierOut, 8'h00);
    check8("R1 iir", iirOut, 8'h01);
    checkIrq("R1", 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      lineErr = VEC[i].err; dataReady = VEC[i].dr; rxCount = VEC[i].cnt;
      rxTrigLevel = VEC[i].trig; fifoEn = VEC[i].fen;
      timeoutPend = VEC[i].tmo; modemDelta = VEC[i].dlt;
      ierWrEn = 1'b1; ierWrData = VEC[i].ier;
      @(negedge clk);
      ierWrEn = 1'b0;
      check8($sformatf("R2/R3 vec%0d iir", i), iirOut, VEC[i].exp);
      checkIrq($sformatf("R11 vec%0d", i), VEC[i].exp[0] == 1'b0);
    end

    clearSrc();
    thrEmpty = 1'b1;
    pulse(1'b1, 4'h2, 1'b0, 1'b0, 1'b0);
    check8("R8 enable sets", iirOut, 8'h02);
    checkIrq("R8 enable sets", 1'b1);
    pulse(1'b1, 4'h3, 1'b0, 1'b0, 1'b0);
    check8("R8 unchanged bit keeps", iirOut, 8'h02);
    pulse(1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
    check8("R7 read clears", iirOut, 8'h01);
    checkIrq("R7 read clears", 1'b0);
    thrEmpty = 1'b0;
    pulse(1'b1, 4'h1, 1'b0, 1'b0, 1'b0);
    pulse(1'b1, 4'h3, 1'b0, 1'b0, 1'b0);
    check8("R8 not empty", iirOut, 8'h01);
    pulse(1'b0, 4'h0, 1'b0, 1'b0, 1'b1);
    check8("R9 fifo reset sets", iirOut, 8'h02);
    pulse(1'b0, 4'h0, 1'b0, 1'b1, 1'b0);
    check8("R9 holding write clears", iirOut, 8'h01);
    pulse(1'b0, 4'h0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    lineErr = 4'h1;
    pulse(1'b1, 4'h7, 1'b0, 1'b0, 1'b0);
    check8("R2 line hides thre", iirOut, 8'h06);
    pulse(1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
    lineErr = 4'h0;
    #1;
    check8("R7 other id keeps flag", iirOut, 8'h02);
    pulse(1'b0, 4'h0, 1'b1, 1'b0, 1'b1);
    check8("R9 reset beats read", iirOut, 8'h02);
    checkIrq("R9 reset beats read", 1'b1);
    pulse(1'b0, 4'h0, 1'b0, 1'b1, 1'b1);
    check8("R9 reset beats write", iirOut, 8'h02);
    pulse(1'b1, 4'h5, 1'b0, 1'b0, 1'b0);
    check8("R10 ier readback", ierOut, 8'h05);
    check8("R8 disable clears", iirOut, 8'h01);

    pulse(1'b1, 4'h8, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    modemDelta = 4'h2;
    #1;
    check8("R11 id immediate", iirOut, 8'h00);
    checkIrq("R11 before edge", 1'b0);
    @(negedge clk);
    checkIrq("R11 after edge", 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule